// File: doc/BRIEF.md
# Nested Priority Fast-Interrupt Vector Unit

This block sits between a set of pending fast-interrupt sources and the processor core. Every cycle it picks the most urgent pending source, which is the one with the lowest priority number, and the lowest source index among sources that share that number. It presents a 32-bit vector word that combines a programmable base with that source's index. Software reads this word inside its handler to find the service routine.

When nesting is turned on, reading the vector word marks the winner's priority level as in service. An in-service level holds off that level and every less urgent level from raising the request to the core. Only strictly more urgent sources can then interrupt the running handler. Software retires levels one at a time by writing to the status register. Each write clears the most urgent level that is still in service, and the written data plays no part. When nesting is off, reads leave the status register alone.

The register port has separate read and write strobes, each with its own select. Select 0 addresses the vector word and select 1 addresses the in-service status. Read data is combinational from the current state.

Top module: `nest_vec_unit`

## Requirements
- R1: The vector word is laid out as follows: bits 31:23 are zero, bits 22:7 hold `vec_base`, bits 6:2 hold the winner's source index in plain binary (source 4 reads as 00100), and bits 1:0 are zero. `rd_data` equals this word whenever `rd_sel` is 0.
- R2: The winner is the pending source with the numerically lowest 3-bit priority. Priority 0 is the most urgent. Ties go to the lowest source index.
- R3: While `nest_en` is 0, a vector read (`rd_en`=1, `rd_sel`=0) leaves `isr_stat` unchanged.
- R4: While `nest_en` is 1, a vector read with at least one source pending sets bit P of `isr_stat` on that clock edge, where P is the winner's priority.
- R5: Each write to the status register (`wr_en`=1, `wr_sel`=1) clears only the lowest-index set bit of `isr_stat`. For example, 0x09 becomes 0x08 after one write and 0x00 after a second. A write when the register is 0x00 leaves it at 0x00.
- R6: `core_req` is 1 exactly when some pending source has a priority number strictly below the index of the lowest set `isr_stat` bit, or when `isr_stat` is zero and any source is pending.
- R7: `isr_stat` resets to 0x00. `rd_data` equals {24 zero bits, `isr_stat`} whenever `rd_sel` is 1.
- R8: A vector read while no source is pending returns the base with index 0 and leaves `isr_stat` unchanged.
- R9: A status write and a nesting vector read on the same edge first clear the lowest set bit of the old value, then set the winner's priority bit.
- R10: A write with `wr_sel`=0 has no effect on `isr_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | 28 | Enabled and pending source lines |
| src_prio | input | 84 | Priority per source, 3 bits each; source i uses bits 3i+2:3i |
| nest_en | input | 1 | Nesting enable |
| vec_base | input | 16 | Base value placed in vector bits 22:7 |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Read select: 0 vector word, 1 status |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write select: 1 status, 0 no target |
| rd_data | output | 32 | Read data for the selected register |
| vec_word | output | 32 | Current vector word |
| isr_stat | output | 8 | In-service levels, bit i for priority i |
| core_req | output | 1 | Masked fast-interrupt request to the core |

## Verification
The assertions check the following on every cycle:
- the zero padding of the vector and status words;
- the index range;
- the push of the winner's priority level, and the hold of the status register when nesting is off, on an empty read, or on a write to the vector select;
- the rule that a status write drops exactly one bit;
- the request gating at its two extremes.

Only the bench's scenarios can show the exact choice of winner among tied and mixed priorities, and the exact request threshold when an in-service level sits between pending priorities. The same holds for the 0x09 to 0x08 to 0x00 pop sequence and for the ordering of a pop and a push that land on the same edge.

// File: rtl/nvu_pkg.sv
package nvu_pkg;
  localparam int PRIO_W  = 3;
  localparam int LVL     = 1 << PRIO_W;
  localparam int BASE_W  = 16;
  localparam int IDX_W   = 5;
  localparam int WORD_W  = 32;
  localparam int TOP_PAD = WORD_W - BASE_W - IDX_W - 2;

  typedef logic [LVL-1:0]    lvl_vec_t;
  typedef logic [PRIO_W:0]   thresh_t;
  typedef logic [BASE_W-1:0] base_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [WORD_W-1:0] word_t;

  // index of most urgent in-service level, or LVL when none is set
  function automatic thresh_t lowest_level(input lvl_vec_t v);
    thresh_t r;
    r = thresh_t'(LVL);
    for (int k = LVL - 1; k >= 0; k--)
      if (v[k]) r = thresh_t'(k);
    return r;
  endfunction

  // retire the most urgent in-service level
  function automatic lvl_vec_t drop_lowest(input lvl_vec_t v);
    return v & (v - lvl_vec_t'(1));
  endfunction

  function automatic word_t pack_vector(input base_t b, input idx_t i);
    return {{TOP_PAD{1'b0}}, b, i, 2'b00};
  endfunction
endpackage

// File: rtl/nvu_arbiter.sv
module nvu_arbiter
  import nvu_pkg::*;
#(
  parameter int NUM_SRC = 28
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  output logic                      win_valid,
  output idx_t                      win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (!win_valid || prio[i*PRIO_W +: PRIO_W] < win_prio)) begin
        win_valid = 1'b1;
        win_idx   = idx_t'(i);
        win_prio  = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/nvu_isr_stack.sv
module nvu_isr_stack
  import nvu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_lvl,
  input  logic              pop,
  output lvl_vec_t          isr
);
  lvl_vec_t after_pop, isr_nxt;

  always_comb begin
    after_pop = pop ? drop_lowest(isr) : isr;
    isr_nxt   = after_pop;
    if (push) isr_nxt[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= isr_nxt;
  end
endmodule

// File: rtl/nvu_req_gate.sv
module nvu_req_gate
  import nvu_pkg::*;
#(
  parameter int NUM_SRC = 28
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  lvl_vec_t                  isr,
  output logic                      req
);
  thresh_t            limit;
  logic [NUM_SRC-1:0] src_ok;

  assign limit = lowest_level(isr);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_ok[g] = pend[g] && ({1'b0, prio[g*PRIO_W +: PRIO_W]} < limit);
  end

  assign req = |src_ok;
endmodule

// File: rtl/nest_vec_unit.sv
module nest_vec_unit
  import nvu_pkg::*;
#(
  parameter int NUM_SRC = 28,
  localparam int PRIO_BITS = NUM_SRC * PRIO_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_pend,
  input  logic [PRIO_BITS-1:0] src_prio,
  input  logic                 nest_en,
  input  logic [BASE_W-1:0]    vec_base,
  input  logic                 rd_en,
  input  logic                 rd_sel,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  output logic [WORD_W-1:0]    rd_data,
  output logic [WORD_W-1:0]    vec_word,
  output logic [LVL-1:0]       isr_stat,
  output logic                 core_req
);
  logic              win_valid;
  idx_t              win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic              push_evt;
  logic              pop_evt;

  nvu_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend(src_pend), .prio(src_prio),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  assign push_evt = rd_en && !rd_sel && nest_en && win_valid;
  assign pop_evt  = wr_en && wr_sel;

  nvu_isr_stack u_stk (
    .clk(clk), .rst_n(rst_n),
    .push(push_evt), .push_lvl(win_prio), .pop(pop_evt),
    .isr(isr_stat)
  );

  nvu_req_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .pend(src_pend), .prio(src_prio), .isr(isr_stat), .req(core_req)
  );

  assign vec_word = pack_vector(vec_base, win_idx);
  assign rd_data  = rd_sel ? {{(WORD_W-LVL){1'b0}}, isr_stat} : vec_word;
endmodule

// File: rtl/nvu_checker.sv
module nvu_checker
  import nvu_pkg::*;
#(
  parameter int NUM_SRC = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_pend,
  input logic               nest_en,
  input logic               rd_en,
  input logic               rd_sel,
  input logic               wr_en,
  input logic               wr_sel,
  input logic [WORD_W-1:0]  rd_data,
  input logic [WORD_W-1:0]  vec_word,
  input logic [LVL-1:0]     isr_stat,
  input logic               core_req,
  input logic [PRIO_W-1:0]  win_prio,
  input logic               push_evt,
  input logic               pop_evt
);
  AST_VEC_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    vec_word[31:23] == '0 && vec_word[1:0] == '0); // R1
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vec_word[6:2]) < NUM_SRC); // R2
  AST_NO_NEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en && !pop_evt) |=> $stable(isr_stat)); // R3
  AST_PUSH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> isr_stat[$past(win_prio)]); // R4
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !push_evt) |=>
      (($past(isr_stat) == '0) ? (isr_stat == '0) :
       (($countones(isr_stat) + 1 == $countones($past(isr_stat))) &&
        ((isr_stat & ~$past(isr_stat)) == '0)))); // R5
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    isr_stat[0] |-> !core_req); // R6
  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_stat == '0 && |src_pend) |-> core_req); // R6
  AST_STAT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> rd_data[31:8] == '0); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && src_pend == '0 && !pop_evt) |=> $stable(isr_stat)); // R8
  AST_WR_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !push_evt) |=> $stable(isr_stat)); // R10
endmodule

bind nest_vec_unit nvu_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .nest_en(nest_en),
  .rd_en(rd_en), .rd_sel(rd_sel), .wr_en(wr_en), .wr_sel(wr_sel),
  .rd_data(rd_data), .vec_word(vec_word), .isr_stat(isr_stat),
  .core_req(core_req), .win_prio(win_prio),
  .push_evt(push_evt), .pop_evt(pop_evt)
);

// File: tb/tb_nest_vec_unit.sv
module tb_nest_vec_unit;
  localparam int NS = 28;
  localparam logic [15:0] BASE = 16'hA5C3;
  // row: pend, src_a, prio_a, src_b, prio_b, default prio, expected winner
  localparam logic [51:0] TBL [8] = '{
    {28'h0000010, 5'd4,  3'd3, 5'd0,  3'd7, 3'd7, 5'd4},
    {28'hFFFFFFF, 5'd20, 3'd1, 5'd9,  3'd1, 3'd5, 5'd9},
    {28'h8000001, 5'd27, 3'd0, 5'd0,  3'd6, 3'd6, 5'd27},
    {28'h0F00000, 5'd22, 3'd2, 5'd21, 3'd2, 3'd2, 5'd20},
    {28'h0000000, 5'd3,  3'd1, 5'd5,  3'd2, 3'd4, 5'd0},
    {28'h0000300, 5'd9,  3'd3, 5'd8,  3'd3, 3'd4, 5'd8},
    {28'h8000000, 5'd1,  3'd0, 5'd2,  3'd0, 3'd0, 5'd27},
    {28'h5555555, 5'd13, 3'd0, 5'd26, 3'd2, 3'd7, 5'd26}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src_pend = '0;
  logic [NS*3-1:0] src_prio = '1;
  logic nest_en = 1'b0, rd_en = 1'b0, rd_sel = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] vec_base = BASE;
  logic [31:0] rd_data, vec_word;
  logic [7:0] isr_stat;
  logic core_req;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nest_vec_unit dut (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_prio(src_prio),
    .nest_en(nest_en), .vec_base(vec_base), .rd_en(rd_en), .rd_sel(rd_sel),
    .wr_en(wr_en), .wr_sel(wr_sel), .rd_data(rd_data), .vec_word(vec_word),
    .isr_stat(isr_stat), .core_req(core_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] vword(input logic [4:0] idx);
    return {9'd0, BASE, idx, 2'b00};
  endfunction

  task automatic set_prio(input int s, input logic [2:0] p);
    src_prio[s*3 +: 3] = p;
  endtask

  task automatic strobe(input bit rd, input bit rs, input bit wr, input bit ws);
    @(negedge clk);
    rd_en = rd; rd_sel = rs; wr_en = wr; wr_sel = ws;
    @(negedge clk);
    rd_en = 0; rd_sel = 0; wr_en = 0; wr_sel = 0;
  endtask

  initial begin
    #200000ns;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    rd_sel = 1'b1; #0.5;
    chk("R7 reset status", rd_data, 32'h0);
    chk("R7 reset isr", {24'd0, isr_stat}, 32'h0);
    rd_sel = 1'b0;

    // R1 R2 R6 R8 table walk, status empty
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      for (int s = 0; s < NS; s++) set_prio(s, TBL[r][7:5]);
      set_prio(int'(TBL[r][23:19]), TBL[r][18:16]);
      set_prio(int'(TBL[r][15:11]), TBL[r][10:8]);
      src_pend = TBL[r][51:24];
      #1;
      chk("R1 R2 vector word", rd_data, vword(TBL[r][4:0]));
      chk("R6 request empty status", {31'd0, core_req}, {31'd0, |TBL[r][51:24]});
    end

    // R3: reads without nesting
    @(negedge clk);
    src_prio = '1; set_prio(5, 3'd3); src_pend = 28'h0000020;
    strobe(1, 0, 0, 0);
    chk("R3 no nest read", {24'd0, isr_stat}, 32'h0);

    // R4 push level 3
    nest_en = 1'b1;
    strobe(1, 0, 0, 0);
    chk("R4 push level3", {24'd0, isr_stat}, 32'h08);
    chk("R6 same level blocked", {31'd0, core_req}, 32'h0);

    set_prio(6, 3'd1); src_pend = 28'h0000060; #1;
    chk("R6 more urgent passes", {31'd0, core_req}, 32'h1);
    chk("R2 urgent winner", rd_data, vword(5'd6));
    strobe(1, 0, 0, 0);
    chk("R4 push level1", {24'd0, isr_stat}, 32'h0A);

    // R10 write to vector select
    strobe(0, 0, 1, 0);
    chk("R10 vector write ignored", {24'd0, isr_stat}, 32'h0A);

    // R5 pops
    strobe(0, 0, 1, 1);
    chk("R5 pop to 08", {24'd0, isr_stat}, 32'h08);
    set_prio(7, 3'd0); src_pend = 28'h00000E0;
    strobe(1, 0, 0, 0);
    chk("R5 build 09", {24'd0, isr_stat}, 32'h09);
    chk("R6 level0 blocks all", {31'd0, core_req}, 32'h0);
    strobe(0, 0, 1, 1);
    chk("R5 09 to 08", {24'd0, isr_stat}, 32'h08);
    strobe(0, 0, 1, 1);
    chk("R5 08 to 00", {24'd0, isr_stat}, 32'h00);
    strobe(0, 0, 1, 1);
    chk("R5 empty stays 00", {24'd0, isr_stat}, 32'h00);

    // R8 empty read with a level held
    src_pend = 28'h0000020;
    strobe(1, 0, 0, 0);
    chk("R4 push level3 again", {24'd0, isr_stat}, 32'h08);
    src_pend = '0; #1;
    chk("R8 empty vector", rd_data, vword(5'd0));
    strobe(1, 0, 0, 0);
    chk("R8 empty read keeps", {24'd0, isr_stat}, 32'h08);

    // R9 pop and push together
    src_pend = 28'h0000040;
    strobe(1, 0, 1, 1);
    chk("R9 pop then push", {24'd0, isr_stat}, 32'h02);
    chk("R6 level1 blocks prio1", {31'd0, core_req}, 32'h0);
    rd_sel = 1'b1; #0.5;
    chk("R7 status read", rd_data, 32'h00000002);
    rd_sel = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule